// File: doc/BRIEF.md
# Local Bus Watchdog Timer

This block watches the data phases of a synchronous local bus and catches accesses that never complete, such as a read aimed at a memory region with nothing fitted. While the active-low data-enable input is low, an 8-bit counter advances once per clock. Each READY strobe from the addressed slave reloads the counter to zero, so every beat of a burst gets a full window of its own. When the strobe arrives together with the burst-last indication, the data phase is complete and the watch stops counting.

If the counter reaches the programmed limit before READY arrives, the block drives an active-low bus-error output. The processor takes this as the end of the hung cycle and recovers. The error output stays low until data enable is released, and then it clears. A limit of zero switches the watch off.

Top module: `bus_watch_timer`

## Requirements
- R1: After reset, `berr_n` is high and no error is pending.
- R2: While `den_n` is high at a clock edge, `berr_n` is high after that edge and the timer restarts from zero.
- R3: With a nonzero `limit` of L, a data phase that sees no READY drives `berr_n` low after the L-th consecutive rising edge that samples `den_n` low and `ready_n` high.
- R4: An edge that samples `ready_n` low (0 = READY) during a data phase with no error pending reloads the timer, so the next beat again needs L READY-free edges before an error is raised.
- R5: An edge that samples `ready_n` low and `blast_n` low (0 = last beat) ends the watch for the rest of that data phase, so no error follows while `den_n` stays low.
- R6: Once low, `berr_n` stays low while `den_n` stays low. It returns high after the first edge that samples `den_n` high.
- R7: A `limit` of zero disables the watch: `berr_n` is never driven low by a data phase that starts under that limit.
- R8: The count is 8 bits wide and does not wrap. A `limit` of 255 raises the error after exactly 255 READY-free edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| den_n | input | 1 | Active-low data enable; low during a data phase |
| ready_n | input | 1 | Active-low READY from the addressed slave |
| blast_n | input | 1 | Active-low burst-last indication |
| limit | input | 8 | Timeout limit in clocks; 0 disables the watch |
| berr_n | output | 1 | Active-low bus-error output |

## Verification
The assertions assume that `limit` holds steady during a data phase and changes only while `den_n` is high. They also assume that READY is taken as meaningful only while `den_n` is low. The stimulus changes `limit` only between data phases, with `den_n` high. Within a phase it drives READY and burst-last freely, including strobes after the last beat and strobes while an error is already pending.

// File: rtl/bus_watch_timer.sv
module bus_watch_timer #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          den_n,
  input  logic          ready_n,
  input  logic          blast_n,
  input  logic [CW-1:0] limit,
  output logic          berr_n
);

  localparam logic [CW-1:0] ZERO = '0;
  localparam logic [CW-1:0] ONE  = {{(CW-1){1'b0}}, 1'b1};

  logic [CW-1:0] cnt;
  logic          tripped;
  logic          done;
  logic          off;

  wire active = !den_n;
  wire beat   = active && !ready_n;
  wire last   = beat && !blast_n;
  wire expire = active && ready_n && !done && !off && !tripped
                && (cnt == limit - ONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= ZERO;
      tripped <= 1'b0;
      done    <= 1'b0;
      off     <= 1'b0;
    end else if (!active) begin
      cnt     <= ZERO;
      tripped <= 1'b0;
      done    <= 1'b0;
      off     <= (limit == ZERO);
    end else if (!tripped && !done && !off) begin
      if (beat) begin
        cnt  <= ZERO;
        done <= last;
      end else if (expire) begin
        tripped <= 1'b1;
      end else begin
        cnt <= cnt + ONE;
      end
    end
  end

  assign berr_n = !tripped;

  p_idle_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
    den_n |=> berr_n);

  p_err_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!berr_n && !den_n) |=> !berr_n);

  p_ready_reload_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!den_n && !ready_n && berr_n) |=> berr_n);

  p_last_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !den_n) |=> berr_n);

  p_disabled_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (off && !den_n) |=> berr_n);

  p_fall_cause_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(berr_n) |-> ($past(!den_n) && $past(ready_n)));

  p_no_wrap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!den_n && berr_n && !off && !done && $stable(limit)) |-> (cnt < limit));

endmodule

// File: tb/tb_bus_watch_timer.sv
module tb_bus_watch_timer;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       den_n = 1'b1;
  logic       ready_n = 1'b1;
  logic       blast_n = 1'b1;
  logic [7:0] limit = 8'd4;
  logic       berr_n;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  string tag = "R1";

  int  m_cnt = 0;
  bit  m_trip = 0, m_done = 0, m_off = 0;

  bus_watch_timer dut (.clk(clk), .rst_n(rst_n), .den_n(den_n), .ready_n(ready_n),
                       .blast_n(blast_n), .limit(limit), .berr_n(berr_n));

  always #2.5 clk = ~clk;

  function automatic bit exp_berr();
    return !m_trip;
  endfunction

  task automatic model_edge();
    if (den_n) begin
      m_cnt = 0; m_trip = 0; m_done = 0; m_off = (limit == 0);
    end else if (!m_trip && !m_done && !m_off) begin
      if (!ready_n) begin
        m_cnt = 0; m_done = !blast_n;
      end else if (m_cnt + 1 >= int'(limit)) begin
        m_trip = 1;
      end else begin
        m_cnt++;
      end
    end
  endtask

  task automatic check();
    checks++;
    if (berr_n !== exp_berr()) begin
      errors++;
      $display("FAIL %s: berr_n=%b expected %b at cycle %0d", tag, berr_n, exp_berr(), cycles);
    end
  endtask

  task automatic step(input bit d, input bit r, input bit b);
    @(negedge clk);
    den_n = d; ready_n = r; blast_n = b;
    model_edge();
    @(negedge clk);
    check();
    den_n = d; ready_n = r; blast_n = b;
  endtask

  task automatic cyc(input bit d, input bit r, input bit b);
    den_n = d; ready_n = r; blast_n = b;
    @(posedge clk);
    model_edge();
    @(negedge clk);
    check();
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++; checks++;
      $display("FAIL watchdog: run hung, actual cycles=%0d expected < 150000", cycles);
      finish_run();
    end
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    repeat (3) @(negedge clk);
    tag = "R1"; check();
    rst_n = 1'b1;
    @(negedge clk);

    tag = "R2"; limit = 8'd4;
    for (int i = 0; i < 4; i++) cyc(1, 0, 0);

    tag = "R3";
    for (int i = 0; i < 6; i++) cyc(0, 1, 1);
    tag = "R6";
    for (int i = 0; i < 3; i++) cyc(0, 0, 0);
    cyc(1, 1, 1); cyc(1, 1, 1);

    tag = "R4";
    for (int k = 0; k < 3; k++) begin
      for (int i = 0; i < 3; i++) cyc(0, 1, 1);
      cyc(0, 0, 1);
    end
    for (int i = 0; i < 5; i++) cyc(0, 1, 1);
    cyc(1, 1, 1);

    tag = "R5";
    cyc(0, 1, 1); cyc(0, 0, 0);
    for (int i = 0; i < 10; i++) cyc(0, 1, 1);
    cyc(1, 1, 1);

    tag = "R7"; limit = 8'd0; cyc(1, 1, 1);
    for (int i = 0; i < 300; i++) cyc(0, 1, 1);
    cyc(1, 1, 1);

    tag = "R8"; limit = 8'd255; cyc(1, 1, 1);
    for (int i = 0; i < 258; i++) cyc(0, 1, 1);
    cyc(1, 1, 1);

    tag = "R3"; limit = 8'd1; cyc(1, 1, 1);
    cyc(0, 1, 1); cyc(0, 1, 1); cyc(1, 1, 1);

    tag = "R3/R4";
    for (int p = 0; p < 400; p++) begin
      limit = ($urandom_range(0, 9) == 0) ? 8'd0 : 8'($urandom_range(1, 12));
      cyc(1, $urandom_range(0, 1), $urandom_range(0, 1));
      for (int i = 0; i < int'($urandom_range(1, 30)); i++)
        cyc(0, ($urandom_range(0, 3) != 0), ($urandom_range(0, 3) != 0));
    end
    cyc(1, 1, 1);

    tag = "R1";
    rst_n = 1'b0; den_n = 1'b0; @(negedge clk);
    m_cnt = 0; m_trip = 0; m_done = 0; m_off = 0;
    check();
    finish_run();
  end
endmodule